// File: doc/BRIEF.md
# Pulse-Coded Cassette Bit Renderer

This block turns a stream of bytes into a one-bit audio waveform of the kind a 500-baud home-computer cassette interface expects. A counter that never stops divides time into bit cells of fixed length. Each cell starts with a sync pulse. A second pulse follows later in the same cell only when the bit being sent is 1. Bytes go out most significant bit first, back to back. There are no start, stop or parity bits.

The block asks for its own data. Two cycles before a cell ends, and only when that cell carries the last bit of the current byte, it raises a one-cycle request. The source must present the next byte on the following cycle, which is the final cycle of the cell. The byte is captured there, and its first bit starts in the next cell. There is no start or stop input. Holding reset keeps the block silent. After reset is released, the first cell is silent and only fetches the first byte.

The default timing assumes a 1.774 MHz clock. That gives a 3548-cycle cell, a sync pulse in cycles 0 to 199 and a data pulse in cycles 1774 to 1973. All of these are parameters.

Top module: `cas_bit_render`

## Requirements
- R1: Cell positions run 0 to CELL_CYCLES-1 and then restart at 0. Position 0 holds for the first cycle after reset is released, and each clock edge advances the position by one.
- R2: In every cell after the first, tape_out is 1 at positions SYNC_START to SYNC_END-1.
- R3: In every cell after the first, tape_out at positions DATA_START to DATA_END-1 equals the bit that cell carries (1 gives a pulse, 0 gives none).
- R4: At every position outside the sync and data regions, tape_out is 0.
- R5: Each byte fills eight consecutive cells, bit 7 first and bit 0 last. The next byte starts in the very next cell, with no gap cell.
- R6: byte_req is high for exactly one cycle, at position CELL_CYCLES-2. This happens in the last cell of each byte and in the first cell after reset. It is low at all other times.
- R7: byte_in is sampled only in the cycle that follows byte_req, at position CELL_CYCLES-1. Values on byte_in in any other cycle have no effect on tape_out.
- R8: After reset is released, the whole first cell has tape_out at 0. The byte captured at the end of that cell is the first one sent.
- R9: While reset is held, tape_out and byte_req are 0. After the next release, the block starts again as in R1 and R8, whatever it was doing before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that sets the cell timing |
| rst | input | 1 | Synchronous reset, active high; holding it keeps the block silent |
| byte_in | input | 8 | Next byte, captured in the cycle after byte_req |
| tape_out | output | 1 | One-bit audio waveform |
| byte_req | output | 1 | One-cycle request for the next byte |

## Verification
The bench places random bytes on byte_in in every cycle except the capture cycle. A design that sampled the input one cycle early or late would therefore send garbage, and the waveform would no longer match the byte list. Directed bytes 0xA5, 0x00 and 0xFF exercise bit order and the all-silent and all-pulse data regions. A renderer that sent LSB first, or that put an extra cell between bytes, would shift every later data pulse. A second reset in the middle of a cell checks that the block stays silent while reset is held and restarts cleanly with an idle first cell. A design that kept its old position or its partly sent byte would put its pulses at the wrong positions.

// File: rtl/cas_bit_render.sv
module cas_bit_render #(
  parameter int CELL_CYCLES = 3548,
  parameter int SYNC_START  = 0,
  parameter int SYNC_END    = 200,
  parameter int DATA_START  = 1774,
  parameter int DATA_END    = 1974
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_in,
  output logic       tape_out,
  output logic       byte_req
);
  localparam int CW = $clog2(CELL_CYCLES);
  localparam logic [CW-1:0] POS_LAST = CW'(CELL_CYCLES - 1);
  localparam logic [CW-1:0] POS_REQ  = CW'(CELL_CYCLES - 2);

  logic [CW-1:0] cnt;
  logic [7:0]    shreg;
  logic [2:0]    rem;
  logic          active;

  wire wrap     = (cnt == POS_LAST);
  wire last_bit = (rem == 3'd0);
  wire in_sync  = (int'(cnt) >= SYNC_START) && (int'(cnt) < SYNC_END);
  wire in_data  = (int'(cnt) >= DATA_START) && (int'(cnt) < DATA_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      shreg  <= '0;
      rem    <= '0;
      active <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        if (last_bit) begin
          shreg  <= byte_in;
          rem    <= 3'd7;
          active <= 1'b1;
        end else begin
          shreg <= {shreg[6:0], 1'b0};
          rem   <= rem - 3'd1;
        end
      end
    end
  end

  assign byte_req = (cnt == POS_REQ) && last_bit;
  assign tape_out = active && (in_sync || (in_data && shreg[7]));
endmodule

// File: rtl/cas_bit_render_chk.sv
module cas_bit_render_chk #(
  parameter int CELL_CYCLES = 3548,
  parameter int CW          = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic [7:0]    shreg,
  input logic [2:0]    rem,
  input logic [7:0]    byte_in,
  input logic          tape_out,
  input logic          byte_req
);
  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    byte_req |=> !byte_req);

  // R6
  req_pos_chk: assert property (@(posedge clk) disable iff (rst)
    byte_req |-> (int'(cnt) == CELL_CYCLES - 2));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (rst)
    byte_req |=> ##1 (shreg == $past(byte_in)));

  // R5
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    ((int'(cnt) == CELL_CYCLES - 1) && rem != 3'd0) |=> (shreg == {$past(shreg[6:0]), 1'b0}));

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) == CELL_CYCLES - 1) |=> (cnt == '0));

  // R9
  always @(posedge clk) begin
    if (rst && $past(rst)) begin
      quiet_rst_chk: assert (!tape_out && !byte_req);
    end
  end
endmodule

bind cas_bit_render cas_bit_render_chk #(.CELL_CYCLES(CELL_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .shreg(shreg), .rem(rem),
  .byte_in(byte_in), .tape_out(tape_out), .byte_req(byte_req)
);

// File: tb/sim_cas_bit_render.sv
module sim_cas_bit_render;
  localparam int CLK_PERIOD = 10;
  localparam int CELL = 24;
  localparam int SS = 0, SE = 3, DS = 10, DE = 14;
  localparam int NBYTES = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] byte_in = 8'h00;
  logic tape_out, byte_req;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] bytes [NBYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  cas_bit_render #(.CELL_CYCLES(CELL), .SYNC_START(SS), .SYNC_END(SE),
                   .DATA_START(DS), .DATA_END(DE)) u0 (
    .clk(clk), .rst(rst), .byte_in(byte_in), .tape_out(tape_out), .byte_req(byte_req));

  function automatic logic exp_audio(int t);
    int c = t / CELL;
    int p = t % CELL;
    logic b;
    if (c == 0) return 1'b0;
    b = bytes[(c-1)/8][7 - ((c-1) % 8)];
    return (p >= SS && p < SE) || (p >= DS && p < DE && b);
  endfunction

  function automatic logic exp_req(int t);
    return ((t % CELL) == CELL - 2) && (((t / CELL) % 8) == 0);
  endfunction

  task automatic check(string req, logic act, logic exp, int t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%b expected=%b", req, t, act, exp);
    end
  endtask

  task automatic run_phase(int cycles);
    for (int t = 0; t < cycles; t++) begin
      if (t > 0) @(negedge clk);
      // R2 R3 R4 R5 R8: waveform; R1 R6: request timing
      check((t < CELL) ? "R8" : "R2/R3/R4/R5", tape_out, exp_audio(t), t);
      check("R6", byte_req, exp_req(t), t);
      // R7: only the capture cycle carries the real byte
      if ((t % CELL) == CELL - 1 && ((t / CELL) % 8) == 0)
        byte_in = bytes[t / CELL / 8];
      else
        byte_in = 8'($urandom);
    end
  endtask

  task automatic fill_bytes(bit directed);
    for (int i = 0; i < NBYTES; i++) bytes[i] = 8'($urandom);
    if (directed) begin
      bytes[0] = 8'hA5; bytes[1] = 8'h00; bytes[2] = 8'hFF; bytes[3] = 8'h01;
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    fill_bytes(1'b1);
    repeat (3) @(negedge clk);
    check("R9", tape_out, 1'b0, -1);
    check("R9", byte_req, 1'b0, -1);
    rst = 1'b0;
    run_phase(NBYTES * 8 * CELL);
    // R9: reset in the middle of a cell
    repeat (CELL/2 + 5) @(negedge clk);
    rst = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R9", tape_out, 1'b0, -2);
      check("R9", byte_req, 1'b0, -2);
    end
    fill_bytes(1'b0);
    rst = 1'b0;
    run_phase(NBYTES * 8 * CELL);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule